// File: doc/BRIEF.md
# Tag and Command Slot Checker

This block sits behind a frame deserializer for a 13-slot serial audio link and inspects the slot words of one direction. Each slot word arrives with its slot index and a flag that gives the direction of travel: outgoing from controller to codec, or incoming from codec to controller. A separate frame-start strobe marks the first word of a new frame.

The tag slot (index 0) is always decoded. The block reports the codec-ready bit and the codec ID, and it keeps the twelve slot-valid flags as the mask for the rest of that frame. A later slot of the frame is examined only if its flag is set in that mask. The address slot (index 1) is checked against reserved-bit and even-address rules that depend on the direction. The data slot (index 2) yields a 16-bit register word. Each audio slot (indices 3 to 12) yields a 16-bit sample strobe.

Every result appears one clock after its slot word. Error flags are single-cycle pulses that carry the index of the slot in which the fault was found.

Top module: `slotchk_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every strobe and error output is low, all payload outputs are zero and `valid_mask` is zero.
- R2: A slot word with index 0 is decoded whatever the current mask. One cycle later `tag_vld` is high, `codec_rdy` equals word bit 15, `codec_id` equals bits 1..0, and `valid_mask` equals bits 14..3. Bit 14 is the flag for slot 1 and bit 3 is the flag for slot 12. Word bits 19..16 are ignored.
- R3: A tag word with bit 2 set pulses `err_rsv` with `err_slot` = 0.
- R4: `frame_start` clears the mask. When it comes without a tag word, the word offered in the same cycle and every later word up to the next tag word are checked against an empty mask. When a tag word comes in the same cycle, the tag's flags are loaded.
- R5: A word for slots 1..12 whose flag is clear produces no strobe and no error.
- R6: An outgoing (`dir_in` = 0) valid slot 1 gives `cmd_vld`, with `cmd_rd` = bit 19 (1 = read, 0 = write), `cmd_addr` = bits 18..12 and `cmd_req` = 0. Nonzero bits 11..0 pulse `err_rsv` with `err_slot` = 1.
- R7: An incoming (`dir_in` = 1) valid slot 1 gives `cmd_vld`, with `cmd_rd` = 0, `cmd_addr` = bits 18..12 and `cmd_req` = bits 11..2. A set bit 19 or nonzero bits 1..0 pulse `err_rsv` with `err_slot` = 1.
- R8: In either direction, an odd address (bit 12 set) in a valid slot 1 pulses `err_odd` with `err_slot` = 1.
- R9: A valid slot 2 gives `dat_vld` with `dat_word` = bits 19..4. Nonzero bits 3..0 pulse `err_rsv` with `err_slot` = 2.
- R10: A valid slot k in 3..12 gives `smp_vld`, with `smp_slot` = k and `smp_data` = bits 19..4.
- R11: All results, including errors, are registered one cycle after their word. Payload outputs are zero whenever their strobe is low. Indices 13..15 and cycles with `slot_vld` low produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 1 | A slot word is offered this cycle |
| slot_idx | input | 4 | Slot index 0..12 |
| slot_word | input | 20 | Slot word, MSB first as received |
| dir_in | input | 1 | 1 = incoming (codec to controller), 0 = outgoing |
| frame_start | input | 1 | This cycle begins a new frame |
| tag_vld | output | 1 | Tag slot decoded |
| codec_rdy | output | 1 | Codec-ready bit of the tag |
| codec_id | output | 2 | Codec ID field of the tag |
| valid_mask | output | 12 | Slot-valid mask held for the current frame |
| cmd_vld | output | 1 | Address slot accepted |
| cmd_rd | output | 1 | Access is a read (outgoing only) |
| cmd_addr | output | 7 | Register address |
| cmd_req | output | 10 | Data-request flags (incoming only) |
| dat_vld | output | 1 | Data slot accepted |
| dat_word | output | 16 | Register data |
| smp_vld | output | 1 | Audio sample strobe |
| smp_slot | output | 4 | Slot index of the sample |
| smp_data | output | 16 | Upper 16 bits of the audio slot |
| err_rsv | output | 1 | Reserved-bit error pulse |
| err_odd | output | 1 | Odd-address error pulse |
| err_slot | output | 4 | Slot index of the reported error |

## Verification
The only state inside the block is the frame's valid mask, and it is visible on `valid_mask` one cycle after any tag word or frame start. A stale or wrongly ordered mask shows up on the next gated slot: a strobe that should have stayed silent fires, or an expected one goes missing, in the cycle after that slot's word. The bench therefore follows each mask change with slots whose flags are set and slots whose flags are clear, in both directions. It compares the complete output set every cycle, so a field taken from the wrong bit position is caught as soon as that slot's result is registered.

// File: rtl/slotchk_pkg.sv
package slotchk_pkg;
    localparam int SLOT_W      = 20;
    localparam int TAG_W       = 16;
    localparam int SMP_W       = 16;
    localparam int ADDR_W      = 7;
    localparam int REQ_W       = 10;
    localparam int NSLOT       = 13;
    localparam int IDX_W       = $clog2(NSLOT);
    localparam int VMASK_W     = NSLOT - 1;
    localparam int FIRST_AUDIO = 3;
    localparam int AUD_LSB     = SLOT_W - SMP_W;

    typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} dir_e;

    typedef struct packed {
        logic               rdy;
        logic [VMASK_W-1:0] vmask;
        logic               rsv;
        logic [1:0]         id;
    } tag_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [REQ_W-1:0]  req;
        logic              rsv_err;
        logic              odd_err;
    } cmd_t;

    typedef struct packed {
        logic [SMP_W-1:0] data;
        logic             rsv_err;
    } dat_t;

    function automatic cmd_t chk_addr(logic [SLOT_W-1:0] w, dir_e d);
        cmd_t r;
        r = '0;
        r.addr    = w[18:12];
        r.odd_err = w[12];
        if (d == DIR_OUT) begin
            r.rd      = w[19];
            r.rsv_err = |w[11:0];
        end else begin
            r.req     = w[11:2];
            r.rsv_err = w[19] | (|w[1:0]);
        end
        return r;
    endfunction

    function automatic dat_t chk_data(logic [SLOT_W-1:0] w);
        dat_t r;
        r.data    = w[SLOT_W-1:AUD_LSB];
        r.rsv_err = |w[AUD_LSB-1:0];
        return r;
    endfunction

    function automatic logic slot_enabled(logic [VMASK_W-1:0] m, logic [IDX_W-1:0] idx);
        logic r;
        r = 1'b0;
        for (int k = 1; k <= VMASK_W; k++)
            if (idx == IDX_W'(k)) r = m[VMASK_W-k];
        return r;
    endfunction
endpackage

// File: rtl/slotchk_mask.sv
module slotchk_mask
    import slotchk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               tag_load,
    input  logic [VMASK_W-1:0] tag_vmask,
    output logic [VMASK_W-1:0] eff_mask,
    output logic [VMASK_W-1:0] mask_q
);
    assign eff_mask = frame_start ? '0 : mask_q;

    always_ff @(posedge clk) begin
        if (rst)              mask_q <= '0;
        else if (tag_load)    mask_q <= tag_vmask;
        else if (frame_start) mask_q <= '0;
    end

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !tag_load) |=> (mask_q == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        tag_load |=> (mask_q == $past(tag_vmask)));
endmodule

// File: rtl/slotchk_cmd.sv
module slotchk_cmd
    import slotchk_pkg::*;
(
    input  logic [SLOT_W-1:0] word,
    input  dir_e              dir,
    output cmd_t              cmd,
    output dat_t              dat
);
    always_comb begin
        cmd = chk_addr(word, dir);
        dat = chk_data(word);
    end
endmodule

// File: rtl/slotchk_audio.sv
module slotchk_audio
    import slotchk_pkg::*;
(
    input  logic               slot_vld,
    input  logic [IDX_W-1:0]   slot_idx,
    input  logic [SMP_W-1:0]   upper,
    input  logic [VMASK_W-1:0] eff_mask,
    output logic               smp_hit,
    output logic [SMP_W-1:0]   smp_data
);
    logic [NSLOT-1:0] hit;

    assign hit[FIRST_AUDIO-1:0] = '0;
    for (genvar k = FIRST_AUDIO; k < NSLOT; k++) begin : g_aud
        assign hit[k] = slot_vld && (slot_idx == IDX_W'(k)) && eff_mask[VMASK_W-k];
    end

    assign smp_hit  = |hit;
    assign smp_data = upper;
endmodule

// File: rtl/slotchk_top.sv
module slotchk_top
    import slotchk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_vld,
    input  logic [IDX_W-1:0]   slot_idx,
    input  logic [SLOT_W-1:0]  slot_word,
    input  logic               dir_in,
    input  logic               frame_start,
    output logic               tag_vld,
    output logic               codec_rdy,
    output logic [1:0]         codec_id,
    output logic [VMASK_W-1:0] valid_mask,
    output logic               cmd_vld,
    output logic               cmd_rd,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [REQ_W-1:0]   cmd_req,
    output logic               dat_vld,
    output logic [SMP_W-1:0]   dat_word,
    output logic               smp_vld,
    output logic [IDX_W-1:0]   smp_slot,
    output logic [SMP_W-1:0]   smp_data,
    output logic               err_rsv,
    output logic               err_odd,
    output logic [IDX_W-1:0]   err_slot
);
    tag_t               tg;
    logic               is_tag, cmd_hit, dat_hit, smp_hit;
    logic [VMASK_W-1:0] eff_mask;
    cmd_t               cmd;
    dat_t               dat;
    logic [SMP_W-1:0]   smp_c;

    assign tg     = tag_t'(slot_word[TAG_W-1:0]);
    assign is_tag = slot_vld && (slot_idx == '0);

    slotchk_mask u_mask (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .tag_load(is_tag), .tag_vmask(tg.vmask),
        .eff_mask(eff_mask), .mask_q(valid_mask)
    );

    slotchk_cmd u_cmd (
        .word(slot_word), .dir(dir_e'(dir_in)), .cmd(cmd), .dat(dat)
    );

    slotchk_audio u_aud (
        .slot_vld(slot_vld), .slot_idx(slot_idx),
        .upper(slot_word[SLOT_W-1:AUD_LSB]), .eff_mask(eff_mask),
        .smp_hit(smp_hit), .smp_data(smp_c)
    );

    assign cmd_hit = slot_vld && (slot_idx == IDX_W'(1)) && eff_mask[VMASK_W-1];
    assign dat_hit = slot_vld && (slot_idx == IDX_W'(2)) && eff_mask[VMASK_W-2];

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_vld <= 1'b0; codec_rdy <= 1'b0; codec_id <= '0;
            cmd_vld <= 1'b0; cmd_rd <= 1'b0; cmd_addr <= '0; cmd_req <= '0;
            dat_vld <= 1'b0; dat_word <= '0;
            smp_vld <= 1'b0; smp_slot <= '0; smp_data <= '0;
            err_rsv <= 1'b0; err_odd <= 1'b0; err_slot <= '0;
        end else begin
            tag_vld <= 1'b0; codec_rdy <= 1'b0; codec_id <= '0;
            cmd_vld <= 1'b0; cmd_rd <= 1'b0; cmd_addr <= '0; cmd_req <= '0;
            dat_vld <= 1'b0; dat_word <= '0;
            smp_vld <= 1'b0; smp_slot <= '0; smp_data <= '0;
            err_rsv <= 1'b0; err_odd <= 1'b0; err_slot <= '0;
            if (is_tag) begin
                tag_vld   <= 1'b1;
                codec_rdy <= tg.rdy;
                codec_id  <= tg.id;
                err_rsv   <= tg.rsv;
            end
            if (cmd_hit) begin
                cmd_vld  <= 1'b1;
                cmd_rd   <= cmd.rd;
                cmd_addr <= cmd.addr;
                cmd_req  <= cmd.req;
                err_rsv  <= cmd.rsv_err;
                err_odd  <= cmd.odd_err;
                if (cmd.rsv_err || cmd.odd_err) err_slot <= slot_idx;
            end
            if (dat_hit) begin
                dat_vld  <= 1'b1;
                dat_word <= dat.data;
                err_rsv  <= dat.rsv_err;
                if (dat.rsv_err) err_slot <= slot_idx;
            end
            if (smp_hit) begin
                smp_vld  <= 1'b1;
                smp_slot <= slot_idx;
                smp_data <= smp_c;
            end
        end
    end

    // R11: an error pulse always stems from a word offered one cycle earlier
    assert_err_src_R11: assert property (@(posedge clk) disable iff (rst)
        (err_rsv || err_odd) |-> $past(slot_vld));

    assert_odd_slot_R8: assert property (@(posedge clk) disable iff (rst)
        err_odd |-> (cmd_vld && err_slot == IDX_W'(1)));

    assert_smp_range_R10: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> (smp_slot >= IDX_W'(FIRST_AUDIO) && smp_slot <= IDX_W'(VMASK_W)));

    assert_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && slot_idx != '0 && !frame_start && !slot_enabled(valid_mask, slot_idx))
        |=> !(cmd_vld || dat_vld || smp_vld || err_rsv || err_odd));

    assert_tag_R2: assert property (@(posedge clk) disable iff (rst)
        is_tag |=> (tag_vld && codec_id == $past(slot_word[1:0])));
endmodule

// File: tb/tb_slotchk_top.sv
`timescale 1ns/1ps
module tb_slotchk_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_vld = 1'b0;
    logic [3:0]  slot_idx = '0;
    logic [19:0] slot_word = '0;
    logic        dir_in = 1'b0;
    logic        frame_start = 1'b0;
    logic        tag_vld, codec_rdy, cmd_vld, cmd_rd, dat_vld, smp_vld, err_rsv, err_odd;
    logic [1:0]  codec_id;
    logic [11:0] valid_mask;
    logic [6:0]  cmd_addr;
    logic [9:0]  cmd_req;
    logic [15:0] dat_word, smp_data;
    logic [3:0]  smp_slot, err_slot;

    always #10 clk = ~clk;

    slotchk_top dut (
        .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_idx(slot_idx),
        .slot_word(slot_word), .dir_in(dir_in), .frame_start(frame_start),
        .tag_vld(tag_vld), .codec_rdy(codec_rdy), .codec_id(codec_id),
        .valid_mask(valid_mask), .cmd_vld(cmd_vld), .cmd_rd(cmd_rd),
        .cmd_addr(cmd_addr), .cmd_req(cmd_req), .dat_vld(dat_vld),
        .dat_word(dat_word), .smp_vld(smp_vld), .smp_slot(smp_slot),
        .smp_data(smp_data), .err_rsv(err_rsv), .err_odd(err_odd),
        .err_slot(err_slot)
    );

    typedef struct packed {
        logic tag; logic rdy; logic [1:0] id; logic [11:0] vmask;
        logic cv; logic rd; logic [6:0] addr; logic [9:0] req;
        logic dv; logic [15:0] dat;
        logic sv; logic [3:0] sslot; logic [15:0] sdat;
        logic ersv; logic eodd; logic [3:0] eslot;
    } obs_t;

    obs_t        expq[$];
    string       tagq[$];
    int          n_chk = 0, n_fail = 0;
    logic [11:0] bm = '0;
    bit          done = 1'b0;

    function automatic obs_t observe();
        obs_t o;
        o = '{tag_vld, codec_rdy, codec_id, valid_mask, cmd_vld, cmd_rd, cmd_addr,
              cmd_req, dat_vld, dat_word, smp_vld, smp_slot, smp_data,
              err_rsv, err_odd, err_slot};
        return o;
    endfunction

    task automatic check(string rq, obs_t act, obs_t exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // scoreboard driver: builds expectation from the requirements, then drives
    task automatic put(bit v, int idx, logic [19:0] w, bit dir, bit fs, string rq);
        obs_t e;
        logic [11:0] em;
        logic rs, od;
        e  = '0;
        em = fs ? 12'h0 : bm;
        if (v && idx == 0) begin
            e.tag = 1; e.rdy = w[15]; e.id = w[1:0];
            if (w[2]) e.ersv = 1;
            bm = w[14:3];
        end else begin
            if (fs) bm = '0;
            if (v && idx >= 1 && idx <= 12 && em[12-idx]) begin
                if (idx == 1) begin
                    e.cv = 1; e.addr = w[18:12]; od = w[12];
                    if (!dir) begin e.rd = w[19]; rs = |w[11:0]; end
                    else begin e.req = w[11:2]; rs = w[19] | (|w[1:0]); end
                    e.ersv = rs; e.eodd = od;
                    if (rs || od) e.eslot = 4'd1;
                end else if (idx == 2) begin
                    e.dv = 1; e.dat = w[19:4];
                    if (|w[3:0]) begin e.ersv = 1; e.eslot = 4'd2; end
                end else begin
                    e.sv = 1; e.sslot = 4'(idx); e.sdat = w[19:4];
                end
            end
        end
        e.vmask = bm;
        @(negedge clk);
        slot_vld = v; slot_idx = 4'(idx); slot_word = w; dir_in = dir; frame_start = fs;
        expq.push_back(e);
        tagq.push_back(rq);
    endtask

    // monitor: compares one expectation per driven cycle
    initial begin
        forever begin
            @(posedge clk); #2;
            if (expq.size() > 0) check(tagq.pop_front(), observe(), expq.pop_front());
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 check("R1 reset", observe(), '0);
        @(negedge clk); rst = 1'b0;
        put(0, 0, 20'h0, 0, 0, "R1 idle after reset");
        // frame 1, outgoing, all slots valid, ready, id 2
        put(1, 0, 20'h0FFFA, 0, 1, "R2 tag all valid");
        put(1, 1, 20'hA6000, 0, 0, "R6 read cmd");
        put(1, 2, 20'h12340, 0, 0, "R9 data");
        for (int k = 3; k <= 12; k++)
            put(1, k, {16'hA000 + 16'(k), 4'h5}, 0, 0, "R10 audio sample");
        put(1, 13, 20'hFFFFF, 0, 0, "R11 index 13 ignored");
        put(0, 3, 20'h12345, 0, 0, "R11 no slot_vld");
        // frame 2: reserved tag bit, only slots 1 and 4 valid
        put(1, 0, 20'h04805, 0, 1, "R3 tag reserved bit");
        put(1, 1, 20'h13005, 0, 0, "R6 R8 write odd addr reserved");
        put(1, 2, 20'h12345, 0, 0, "R5 slot 2 skipped");
        put(1, 3, 20'h55555, 0, 0, "R5 slot 3 skipped");
        put(1, 4, 20'hBEEF7, 0, 0, "R10 slot 4 sample");
        // frame 3: start without tag
        put(1, 1, 20'hA6000, 0, 1, "R4 start clears mask");
        put(1, 4, 20'hBEEF7, 0, 0, "R4 empty mask skip");
        // frame 4, incoming, top nibble set in tag, slots 1 and 2 valid
        put(1, 0, 20'hFE000, 1, 1, "R2 tag upper bits ignored");
        put(1, 1, 20'h7CFFC, 1, 0, "R7 status with requests");
        put(1, 1, 20'hFC000, 1, 0, "R7 bit 19 reserved");
        put(1, 1, 20'h7C001, 1, 0, "R7 low bits reserved");
        put(1, 1, 20'h7D000, 1, 0, "R8 odd addr incoming");
        put(1, 2, 20'hBEEFF, 1, 0, "R9 data reserved bits");
        put(1, 3, 20'h11110, 1, 0, "R5 slot 3 invalid incoming");
        put(0, 0, 20'h0, 0, 0, "R11 idle");
        put(0, 0, 20'h0, 0, 0, "R11 idle");
        while (expq.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule